// File: doc/BRIEF.md
# Recursive Vertical-Crosswise Unsigned Multiplier

This block multiplies two unsigned operands of WIDTH bits (2, 4, 8 or 16) and returns their full 2·WIDTH-bit product in the same cycle. It has no clock and no state. Each operand is halved into an upper and a lower part, and four half-width products are formed side by side. The half-width products are built the same way, down to a 2x2 cell made of AND gates and half adders. A merge network then adds the four results at their proper weights.

The merge network is chosen at elaboration time. One form uses ripple adders only. One uses two carry-save rows followed by a carry-resolving ripple. The hybrid form uses one carry-save row and one ripple. Each form can be built trimmed or untrimmed. In the trimmed form, every full adder that has an input tied permanently to zero becomes a half adder. All six variants give the same product.

Top module: `vcm_top`

## Requirements
- R1: The 2x2 cell forms four partial products with AND gates and sums them with two half adders into a 4-bit result equal to the unsigned product of its 2-bit inputs.
- R2: For every pair of WIDTH-bit operands, `product` equals op_a × op_b as an unsigned 2·WIDTH-bit number, combinationally. Zero operands give a zero product.
- R3: For WIDTH ≥ 4, the product equals (a_hi·b_hi)·2^WIDTH + (a_hi·b_lo + a_lo·b_hi)·2^(WIDTH/2) + a_lo·b_lo, where hi and lo are the upper and lower WIDTH/2 bits of each operand.
- R4: The lowest WIDTH/2 product bits equal the lowest WIDTH/2 bits of a_lo·b_lo, taken directly and passing through no adder.
- R5: With STYLE = ADD_RIPPLE (encoding 0), the merge uses three ripple adders: cross-term sum, low-aligned sum, and upper half with both carries.
- R6: With STYLE = ADD_CSAVE (encoding 1), the merge uses two carry-save rows and then one ripple that resolves the saved carries.
- R7: With STYLE = ADD_HYBRID (encoding 2), the merge uses one carry-save row and then one ripple.
- R8: With TRIM = 1, every full adder whose third input is constant zero is built as a half adder, and the product is the same as with TRIM = 0.
- R9: WIDTH 4, 8 and 16 are each built from four instances of half the width, with the 2x2 cell as the base. Only 2, 4, 8 and 16 are legal.
- R10: The final carry out of every merge network is zero, so the largest operands (all ones) give 2^(2·WIDTH) − 2^(WIDTH+1) + 1 without overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | Unsigned multiplicand |
| op_b | input | WIDTH | Unsigned multiplier |
| product | output | 2*WIDTH | Unsigned product of op_a and op_b |

## Verification
The embedded checks are immediate and re-evaluate whenever the operands move. They therefore assume that both operands always carry defined two-state values, and that the adder inputs the trimmed form treats as zero really are tied to zero. The stimulus meets both conditions: it starts from zero operands, and every vector it applies is a complete, defined value. Each vector is applied just after a clock edge and the product is read half a period later, once the network has settled. The 2-, 4- and 8-bit variants see every operand pair. The 16-bit variants see the extreme corners plus random pairs.

// File: rtl/vcm_pkg.sv
package vcm_pkg;

    typedef enum logic [1:0] {
        ADD_RIPPLE = 2'd0,
        ADD_CSAVE  = 2'd1,
        ADD_HYBRID = 2'd2
    } comb_style_e;

    typedef struct packed {
        logic carry;
        logic sum;
    } bit_pair_t;

    function automatic bit_pair_t half_add(input logic x, input logic y);
        bit_pair_t r;
        r.sum   = x ^ y;
        r.carry = x & y;
        return r;
    endfunction

    function automatic bit_pair_t full_add(input logic x, input logic y, input logic z);
        bit_pair_t r;
        r.sum   = x ^ y ^ z;
        r.carry = (x & y) | (x & z) | (y & z);
        return r;
    endfunction

    function automatic bit is_legal_width(input int w);
        return (w == 2) || (w == 4) || (w == 8) || (w == 16);
    endfunction

endpackage

// File: rtl/vcm_cell2.sv
module vcm_cell2
    import vcm_pkg::*;
(
    input  logic [1:0] a,
    input  logic [1:0] b,
    output logic [3:0] y
);
    logic [3:0] pp;
    bit_pair_t  mid;
    bit_pair_t  top;

    assign pp[0] = a[0] & b[0];
    assign pp[1] = a[1] & b[0];
    assign pp[2] = a[0] & b[1];
    assign pp[3] = a[1] & b[1];

    assign mid = half_add(pp[1], pp[2]);
    assign top = half_add(pp[3], mid.carry);

    assign y = {top.carry, top.sum, mid.sum, pp[0]};

    // R1: gate-level cell matches the arithmetic product
    always_comb begin
        a_r1_cell_product: assert (y == ({2'b00, a} * {2'b00, b}))
            else $error("cell2 result %h for %h x %h", y, a, b);
    end
endmodule

// File: rtl/vcm_ripple.sv
module vcm_ripple
    import vcm_pkg::*;
#(
    parameter int         W        = 4,
    parameter bit         TRIM     = 1'b0,
    parameter logic [W-1:0] ZERO_B = '0,
    parameter bit         ZERO_CIN = 1'b0
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [W:0] cy;
    logic       unused_tied;

    assign cy[0] = cin;

    for (genvar i = 0; i < W; i++) begin : g_bit
        bit_pair_t r;
        if (TRIM && (i == 0) && ZERO_CIN) begin : g_ha_nocin
            assign r = half_add(a[i], b[i]);
        end else if (TRIM && ZERO_B[i]) begin : g_ha_nob
            assign r = half_add(a[i], cy[i]);
        end else begin : g_fa
            assign r = full_add(a[i], b[i], cy[i]);
        end
        assign sum[i]    = r.sum;
        assign cy[i + 1] = r.carry;
    end

    assign cout        = cy[W];
    assign unused_tied = cy[0] ^ (^(b & ZERO_B));

    // R8: inputs a trimmed adder ignores must really be zero
    always_comb begin
        a_r8_b_tied_zero: assert ((b & ZERO_B) == '0)
            else $error("ripple operand bit expected zero is set: %h", b);
        if (ZERO_CIN) begin
            a_r8_cin_tied_zero: assert (cy[0] == 1'b0)
                else $error("ripple carry-in expected zero is set");
        end
    end
endmodule

// File: rtl/vcm_csa_row.sv
module vcm_csa_row
    import vcm_pkg::*;
#(
    parameter int           W      = 4,
    parameter bit           TRIM   = 1'b0,
    parameter logic [W-1:0] ZERO_C = '0
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] c,
    output logic [W-1:0] s,
    output logic [W-1:0] k
);
    logic unused_tied;

    for (genvar i = 0; i < W; i++) begin : g_bit
        bit_pair_t r;
        if (TRIM && ZERO_C[i]) begin : g_ha
            assign r = half_add(a[i], b[i]);
        end else begin : g_fa
            assign r = full_add(a[i], b[i], c[i]);
        end
        assign s[i] = r.sum;
        assign k[i] = r.carry;
    end

    assign unused_tied = ^(c & ZERO_C);

    // R8: third inputs that the trimmed row drops must be zero
    always_comb begin
        a_r8_c_tied_zero: assert ((c & ZERO_C) == '0)
            else $error("carry-save third input expected zero is set: %h", c);
    end
endmodule

// File: rtl/vcm_combine.sv
module vcm_combine
    import vcm_pkg::*;
#(
    parameter int          N     = 4,
    parameter comb_style_e STYLE = ADD_RIPPLE,
    parameter bit          TRIM  = 1'b1
) (
    input  logic [N-1:0]   hh,
    input  logic [N-1:0]   hl,
    input  logic [N-1:0]   lh,
    input  logic [N-1:0]   ll,
    output logic [2*N-1:0] prod
);
    localparam int H = N / 2;
    localparam int U = 3 * H;

    logic [U-1:0] xv;
    logic [U-1:0] upper;
    logic         unused_cout;
    logic         unused_ktop;

    assign xv   = {hh, ll[N-1:H]};
    assign prod = {upper, ll[H-1:0]};

    if (STYLE == ADD_RIPPLE) begin : g_ripple
        logic [N-1:0] s_cross;
        logic [N-1:0] s_low;
        logic [H-1:0] s_high;
        logic         c_cross;
        logic         c_low;

        vcm_ripple #(.W(N), .TRIM(TRIM), .ZERO_B('0), .ZERO_CIN(1'b1)) u_add_cross (
            .a(hl), .b(lh), .cin(1'b0), .sum(s_cross), .cout(c_cross));

        vcm_ripple #(.W(N), .TRIM(TRIM), .ZERO_B('0), .ZERO_CIN(1'b1)) u_add_low (
            .a(s_cross), .b(xv[N-1:0]), .cin(1'b0), .sum(s_low), .cout(c_low));

        vcm_ripple #(.W(H), .TRIM(TRIM), .ZERO_B({{(H-1){1'b1}}, 1'b0}), .ZERO_CIN(1'b0)) u_add_high (
            .a(hh[N-1:H]), .b({{(H-1){1'b0}}, c_cross}), .cin(c_low),
            .sum(s_high), .cout(unused_cout));

        assign upper       = {s_high, s_low};
        assign unused_ktop = 1'b0;
    end else if (STYLE == ADD_CSAVE) begin : g_csave
        logic [N-1:0] s1;
        logic [N-1:0] k1;
        logic [U-1:0] s2;
        logic [U-1:0] k2;

        vcm_csa_row #(.W(N), .TRIM(TRIM), .ZERO_C('0)) u_row_first (
            .a(hl), .b(lh), .c(xv[N-1:0]), .s(s1), .k(k1));

        vcm_csa_row #(.W(U), .TRIM(TRIM), .ZERO_C({{H{1'b0}}, {N{1'b1}}})) u_row_second (
            .a({{H{1'b0}}, s1}),
            .b({{(H-1){1'b0}}, k1, 1'b0}),
            .c({hh[N-1:H], {N{1'b0}}}),
            .s(s2), .k(k2));

        vcm_ripple #(.W(U), .TRIM(TRIM), .ZERO_B({{(U-1){1'b0}}, 1'b1}), .ZERO_CIN(1'b1)) u_resolve (
            .a(s2), .b({k2[U-2:0], 1'b0}), .cin(1'b0), .sum(upper), .cout(unused_cout));

        assign unused_ktop = k2[U-1];
    end else begin : g_hybrid
        logic [N-1:0] s1;
        logic [N-1:0] k1;

        vcm_csa_row #(.W(N), .TRIM(TRIM), .ZERO_C('0)) u_row (
            .a(hl), .b(lh), .c(xv[N-1:0]), .s(s1), .k(k1));

        vcm_ripple #(.W(U), .TRIM(TRIM), .ZERO_B({{(H-1){1'b1}}, {N{1'b0}}, 1'b1}), .ZERO_CIN(1'b1)) u_resolve (
            .a({hh[N-1:H], s1}), .b({{(H-1){1'b0}}, k1, 1'b0}), .cin(1'b0),
            .sum(upper), .cout(unused_cout));

        assign unused_ktop = 1'b0;
    end

    logic [2*N-1:0] recomp;
    assign recomp = {hh, ll} + {{H{1'b0}}, hl, {H{1'b0}}} + {{H{1'b0}}, lh, {H{1'b0}}};

    always_comb begin
        // R3: merged result equals the weighted sum of the four sub-products
        a_r3_recompose: assert (prod == recomp)
            else $error("merge gave %h, weighted sum %h", prod, recomp);
        // R10: nothing escapes above the top product bit
        a_r10_no_overflow: assert ((unused_cout == 1'b0) && (unused_ktop == 1'b0))
            else $error("merge network carried out of the product width");
    end
endmodule

// File: rtl/vcm_mul.sv
module vcm_mul
    import vcm_pkg::*;
#(
    parameter int          N     = 8,
    parameter comb_style_e STYLE = ADD_RIPPLE,
    parameter bit          TRIM  = 1'b1
) (
    input  logic [N-1:0]   a,
    input  logic [N-1:0]   b,
    output logic [2*N-1:0] p
);
    if (N == 2) begin : g_base
        vcm_cell2 u_cell (.a(a), .b(b), .y(p));
    end else begin : g_split
        localparam int H = N / 2;
        logic [N-1:0] q_hh;
        logic [N-1:0] q_hl;
        logic [N-1:0] q_lh;
        logic [N-1:0] q_ll;

        vcm_mul #(.N(H), .STYLE(STYLE), .TRIM(TRIM)) u_hh (
            .a(a[N-1:H]), .b(b[N-1:H]), .p(q_hh));
        vcm_mul #(.N(H), .STYLE(STYLE), .TRIM(TRIM)) u_hl (
            .a(a[N-1:H]), .b(b[H-1:0]), .p(q_hl));
        vcm_mul #(.N(H), .STYLE(STYLE), .TRIM(TRIM)) u_lh (
            .a(a[H-1:0]), .b(b[N-1:H]), .p(q_lh));
        vcm_mul #(.N(H), .STYLE(STYLE), .TRIM(TRIM)) u_ll (
            .a(a[H-1:0]), .b(b[H-1:0]), .p(q_ll));

        vcm_combine #(.N(N), .STYLE(STYLE), .TRIM(TRIM)) u_merge (
            .hh(q_hh), .hl(q_hl), .lh(q_lh), .ll(q_ll), .prod(p));
    end
endmodule

// File: rtl/vcm_top.sv
module vcm_top
    import vcm_pkg::*;
#(
    parameter int          WIDTH = 8,
    parameter comb_style_e STYLE = ADD_RIPPLE,
    parameter bit          TRIM  = 1'b1
) (
    input  logic [WIDTH-1:0]   op_a,
    input  logic [WIDTH-1:0]   op_b,
    output logic [2*WIDTH-1:0] product
);
    localparam int PW = 2 * WIDTH;
    localparam int HW = WIDTH / 2;

    vcm_mul #(.N(WIDTH), .STYLE(STYLE), .TRIM(TRIM)) u_core (
        .a(op_a), .b(op_b), .p(product));

    logic [HW-1:0] low_ref;
    assign low_ref = op_a[HW-1:0] * op_b[HW-1:0];

    // R9: only the supported sizes may be built
    initial begin
        a_r9_legal_width: assert (is_legal_width(WIDTH))
            else $error("unsupported operand width %0d", WIDTH);
    end

    always_comb begin
        // R2: full-width unsigned product
        a_r2_exact_product: assert (product == (PW'(op_a) * PW'(op_b)))
            else $error("product %h for %h x %h", product, op_a, op_b);
        // R4: bottom bits come straight from the low sub-product
        a_r4_low_direct: assert (product[HW-1:0] == low_ref)
            else $error("low product bits %h, expected %h", product[HW-1:0], low_ref);
    end
endmodule

// File: tb/vcm_top_test.sv
module vcm_top_test;
    import vcm_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic [7:0]  a8  = '0;
    logic [7:0]  b8  = '0;
    logic [15:0] a16 = '0;
    logic [15:0] b16 = '0;

    logic [15:0] uut_p;
    logic [3:0]  p2;
    logic [7:0]  p4  [6];
    logic [15:0] p8  [6];
    logic [31:0] p16 [6];

    int n_checks = 0;
    int n_err    = 0;

    typedef struct {
        logic [7:0]  a;
        logic [7:0]  b;
        logic [15:0] a_w;
        logic [15:0] b_w;
        logic [15:0] e8;
        logic [7:0]  e4;
        logic [3:0]  e2;
        logic [31:0] e16;
    } item_t;

    item_t sb_q[$];

    vcm_top #(.WIDTH(8), .STYLE(ADD_HYBRID), .TRIM(1'b1)) uut (
        .op_a(a8), .op_b(b8), .product(uut_p));

    vcm_top #(.WIDTH(2), .STYLE(ADD_RIPPLE), .TRIM(1'b1)) d2 (
        .op_a(a8[1:0]), .op_b(b8[1:0]), .product(p2));

    for (genvar g = 0; g < 6; g++) begin : g_var
        vcm_top #(.WIDTH(4), .STYLE(comb_style_e'(g / 2)), .TRIM((g % 2) == 1)) d4 (
            .op_a(a8[3:0]), .op_b(b8[3:0]), .product(p4[g]));
        vcm_top #(.WIDTH(8), .STYLE(comb_style_e'(g / 2)), .TRIM((g % 2) == 1)) d8 (
            .op_a(a8), .op_b(b8), .product(p8[g]));
        vcm_top #(.WIDTH(16), .STYLE(comb_style_e'(g / 2)), .TRIM((g % 2) == 1)) d16 (
            .op_a(a16), .op_b(b16), .product(p16[g]));
    end

    function automatic string style_tag(input int g);
        string s;
        case (g / 2)
            0:       s = "R5 ripple";
            1:       s = "R6 carry-save";
            default: s = "R7 hybrid";
        endcase
        return (g % 2 == 1) ? {s, " R8 trimmed"} : s;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [7:0] a, input logic [7:0] b,
                         input logic [15:0] aw, input logic [15:0] bw);
        item_t it;
        @(posedge clk);
        a8  = a;
        b8  = b;
        a16 = aw;
        b16 = bw;
        it.a   = a;
        it.b   = b;
        it.a_w = aw;
        it.b_w = bw;
        it.e8  = 16'(a) * 16'(b);
        it.e4  = 8'(a[3:0]) * 8'(b[3:0]);
        it.e2  = 4'(a[1:0]) * 4'(b[1:0]);
        it.e16 = 32'(aw) * 32'(bw);
        sb_q.push_back(it);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    endtask

    // monitor: pops one expected item per cycle and compares every variant
    always @(negedge clk) begin
        if (!rst && sb_q.size() > 0) begin
            item_t it;
            logic [15:0] rc;
            it = sb_q.pop_front();
            chk("R2 product", 32'(uut_p), 32'(it.e8));
            chk("R1 2x2 cell", 32'(p2), 32'(it.e2));
            // R4: low half of the low sub-product
            chk("R4 low bits", 32'(uut_p[3:0]), 32'(4'(it.a[3:0] * it.b[3:0])));
            // R3: weighted recomposition from the four half products
            rc = (16'(it.a[7:4] * it.b[7:4]) << 8)
               + (16'(8'(it.a[7:4]) * 8'(it.b[3:0])) << 4)
               + (16'(8'(it.a[3:0]) * 8'(it.b[7:4])) << 4)
               + 16'(8'(it.a[3:0]) * 8'(it.b[3:0]));
            chk("R3 recomposition", 32'(uut_p), 32'(rc));
            for (int g = 0; g < 6; g++) begin
                chk({style_tag(g), " R9 width 4"}, 32'(p4[g]), 32'(it.e4));
                chk({style_tag(g), " width 8"}, 32'(p8[g]), 32'(it.e8));
                chk({style_tag(g), " R9 width 16"}, p16[g], it.e16);
                if (it.a_w == 16'hFFFF && it.b_w == 16'hFFFF)
                    chk("R10 all-ones no overflow", p16[g], 32'hFFFE_0001);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R2 reset state zero product", 32'(uut_p), 32'h0);
        chk("R2 reset state 16-bit zero", p16[0], 32'h0);

        drive(8'hFF, 8'hFF, 16'hFFFF, 16'hFFFF);
        drive(8'hFF, 8'h01, 16'hFFFF, 16'h0001);
        drive(8'h80, 8'h80, 16'h8000, 16'h8000);
        drive(8'h00, 8'hFF, 16'h0000, 16'hFFFF);
        drive(8'h01, 8'hFF, 16'h0001, 16'hFFFF);
        drive(8'hAA, 8'h55, 16'hAAAA, 16'h5555);
        drive(8'h0F, 8'hF0, 16'h00FF, 16'hFF00);

        for (int i = 0; i < 65536; i++) begin
            drive(8'(i >> 8), 8'(i), 16'($urandom), 16'($urandom));
        end

        repeat (3) @(negedge clk);
        if (sb_q.size() != 0) begin
            n_err++;
            $display("FAIL scoreboard: got %0d pending expected 0", sb_q.size());
        end
        finish_run();
    end
endmodule